// File: doc/BRIEF.md
# Clock Source and Low-Power Mode Controller

This block chooses which of three oscillators (a primary crystal or external source, a low-rate secondary timer oscillator, or an internal RC oscillator) clocks the device, and moves the device between a running mode, an idle mode and a full sleep mode. Software reaches it through one 8-bit register on a plain write-strobe bus with combinational read data. Each oscillator is modelled as a request/ready pair. The block drives an enable to each oscillator and takes a ready back from each.

A source change only completes once the target oscillator is ready. Until then the old source stays in charge. The primary oscillator is guarded by a start-up timer, and its expiry is visible as a read-only status bit. A sleep request stops the CPU clock. A register bit decides whether the peripheral clock keeps running (idle) or everything stops (sleep). A wake input brings the block back to run mode.

Top module: `clkmode_top`

## Requirements
- R1: Register layout: bit 7 is the idle-enable bit and bits 1:0 are the source-select field, both writable and reset to 0. Bit 3 is the start-up status bit, which is read-only. Bits 6:4 and bit 2 always read 0, and writes to them or to bit 3 have no effect.
- R2: The requested source decodes as follows: select 11 gives the internal RC, 10 gives the primary, and 01 gives the secondary. For select 00, `cfgPriDefault`=1 gives the primary and 0 gives the internal RC. `activeSrc` reports the source as 1 for primary, 2 for secondary and 3 for internal RC. After reset it holds the decode of select 00.
- R3: A new source becomes active one cycle after its ready is seen. For the primary, the start-up status must also read 1. Until then `activeSrc` keeps the previous source.
- R4: The status bit resets to 0 when `cfgHsTwoSpeed`=1 and to 1 otherwise. When it is 0, it becomes 1 after OST_CYCLES rising edges during which the primary enable is high.
- R5: A sleep request in run mode with idle-enable=1 enters idle (`pwrMode`=01). In idle, `cpuClkEn`=0 and `periClkEn`=1.
- R6: A sleep request in run mode with idle-enable=0 enters sleep (`pwrMode`=10). In sleep, both clock enables are 0, and every oscillator enable is 0 unless held by a keep-alive input.
- R7: `priEn` stays high in idle when the primary is the active source. It is low in idle for any other source and in sleep.
- R8: `wdtEn`=1 forces `rcEn` high, and `timerKeepAlive`=1 forces `secEn` high, in every mode.
- R9: `wakeReq` in idle or sleep returns `pwrMode` to 00 (run) on the next edge. A sleep request made while `wakeReq` is high is ignored.
- R10: A wake from sleep with the primary active clears the status bit and restarts the start-up timer. The bit reads 1 again after OST_CYCLES edges.
- R11: In run mode, the enable of the active source is high. The enable of a requested but not yet active source is also high. All other oscillator enables are low unless kept alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| cfgPriDefault | input | 1 | Strap: select 00 means primary when 1 |
| cfgHsTwoSpeed | input | 1 | Strap: crystal with two-speed start, status resets to 0 |
| sleepReq | input | 1 | Request to leave run mode |
| wakeReq | input | 1 | Wake event (interrupt or reset) |
| wdtEn | input | 1 | Keep internal RC running |
| timerKeepAlive | input | 1 | Keep secondary oscillator running |
| priReady | input | 1 | Primary oscillator ready |
| secReady | input | 1 | Secondary oscillator ready |
| rcReady | input | 1 | Internal RC ready |
| priEn | output | 1 | Primary oscillator enable |
| secEn | output | 1 | Secondary oscillator enable |
| rcEn | output | 1 | Internal RC enable |
| activeSrc | output | 2 | Active clock source (1 pri, 2 sec, 3 RC) |
| pwrMode | output | 2 | 00 run, 01 idle, 10 sleep |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |

## Verification
The bench builds the block with OST_CYCLES=8. This makes the start-up window short enough to check the exact edge at which the status bit rises, both after reset and after a wake from sleep. With the window this short, the bench can sweep every select code against both strap values, and every source against both idle-enable settings, with a fresh reset for each case. It also checks the cycles just before and after each timer expiry and each ready arrival.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int REG_W    = 8;
  localparam int IDLE_BIT = 7;
  localparam int STAT_BIT = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRI  = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_RC   = 2'd3
  } srcE;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2
  } pmE;

  typedef struct packed {
    logic ostRestart;
    logic priOn;
  } ctrlStrobeT;

  function automatic srcE decodeSel(input logic [1:0] sel, input logic priDefault);
    case (sel)
      2'b11:   return SRC_RC;
      2'b10:   return SRC_PRI;
      2'b01:   return SRC_SEC;
      default: return priDefault ? SRC_PRI : SRC_RC;
    endcase
  endfunction
endpackage

// File: rtl/clkmode_dp.sv
module clkmode_dp
  import clkmode_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             cfgPriDefault,
  input  logic             cfgHsTwoSpeed,
  input  ctrlStrobeT       strobe,
  output logic [REG_W-1:0] rdData,
  output logic             idleEn,
  output srcE              reqSrc,
  output logic             ostDone
);
  localparam int CNT_W = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] OST_LAST = CNT_W'(OST_CYCLES - 1);

  logic             idleEnQ;
  logic [1:0]       selQ;
  logic [CNT_W-1:0] ostCnt;
  logic             ostDoneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleEnQ  <= 1'b0;
      selQ     <= 2'b00;
      ostCnt   <= '0;
      ostDoneQ <= !cfgHsTwoSpeed;
    end else begin
      if (wrEn) begin
        idleEnQ <= wrData[IDLE_BIT];
        selQ    <= wrData[1:0];
      end
      if (strobe.ostRestart) begin
        ostCnt   <= '0;
        ostDoneQ <= 1'b0;
      end else if (strobe.priOn && !ostDoneQ) begin
        if (ostCnt == OST_LAST) begin
          ostDoneQ <= 1'b1;
          ostCnt   <= '0;
        end else begin
          ostCnt <= ostCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[IDLE_BIT] = idleEnQ;
    rdData[STAT_BIT] = ostDoneQ;
    rdData[1:0]      = selQ;
  end

  assign idleEn  = idleEnQ;
  assign ostDone = ostDoneQ;
  assign reqSrc  = decodeSel(selQ, cfgPriDefault);
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgPriDefault,
  input  srcE        reqSrc,
  input  logic       ostDone,
  input  logic       idleEn,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       priReady,
  input  logic       secReady,
  input  logic       rcReady,
  input  logic       wdtEn,
  input  logic       timerKeepAlive,
  output srcE        activeSrc,
  output pmE         pwrMode,
  output logic       priEn,
  output logic       secEn,
  output logic       rcEn,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output ctrlStrobeT strobe
);
  srcE  actQ;
  pmE   modeQ;
  logic tgtReady;
  logic runMode;
  logic idleMode;

  always_comb begin
    case (reqSrc)
      SRC_PRI: tgtReady = priReady && ostDone;
      SRC_SEC: tgtReady = secReady;
      SRC_RC:  tgtReady = rcReady;
      default: tgtReady = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ  <= decodeSel(2'b00, cfgPriDefault);
      modeQ <= PM_RUN;
    end else begin
      if (modeQ == PM_RUN && reqSrc != actQ && tgtReady) actQ <= reqSrc;
      if (modeQ != PM_RUN && wakeReq) begin
        modeQ <= PM_RUN;
      end else if (modeQ == PM_RUN && sleepReq && !wakeReq) begin
        modeQ <= idleEn ? PM_IDLE : PM_SLEEP;
      end
    end
  end

  assign runMode  = (modeQ == PM_RUN);
  assign idleMode = (modeQ == PM_IDLE);

  assign priEn = (runMode && (actQ == SRC_PRI || reqSrc == SRC_PRI))
               || (idleMode && actQ == SRC_PRI);
  assign secEn = (runMode && (actQ == SRC_SEC || reqSrc == SRC_SEC))
               || (idleMode && actQ == SRC_SEC) || timerKeepAlive;
  assign rcEn  = (runMode && (actQ == SRC_RC || reqSrc == SRC_RC))
               || (idleMode && actQ == SRC_RC) || wdtEn;

  assign cpuClkEn  = runMode;
  assign periClkEn = runMode || idleMode;

  assign strobe.priOn      = priEn;
  assign strobe.ostRestart = wakeReq && (modeQ == PM_SLEEP) && (actQ == SRC_PRI);

  assign activeSrc = actQ;
  assign pwrMode   = modeQ;
endmodule

// File: rtl/clkmode_top.sv
module clkmode_top
  import clkmode_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       cfgPriDefault,
  input  logic       cfgHsTwoSpeed,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       wdtEn,
  input  logic       timerKeepAlive,
  input  logic       priReady,
  input  logic       secReady,
  input  logic       rcReady,
  output logic       priEn,
  output logic       secEn,
  output logic       rcEn,
  output logic [1:0] activeSrc,
  output logic [1:0] pwrMode,
  output logic       cpuClkEn,
  output logic       periClkEn
);
  ctrlStrobeT strobe;
  srcE        reqSrc;
  srcE        actSrc;
  pmE         mode;
  logic       idleEn;
  logic       ostDone;

  clkmode_dp #(.OST_CYCLES(OST_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfgPriDefault(cfgPriDefault), .cfgHsTwoSpeed(cfgHsTwoSpeed),
    .strobe(strobe), .rdData(rdData), .idleEn(idleEn),
    .reqSrc(reqSrc), .ostDone(ostDone)
  );

  clkmode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cfgPriDefault(cfgPriDefault),
    .reqSrc(reqSrc), .ostDone(ostDone), .idleEn(idleEn),
    .sleepReq(sleepReq), .wakeReq(wakeReq),
    .priReady(priReady), .secReady(secReady), .rcReady(rcReady),
    .wdtEn(wdtEn), .timerKeepAlive(timerKeepAlive),
    .activeSrc(actSrc), .pwrMode(mode),
    .priEn(priEn), .secEn(secEn), .rcEn(rcEn),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .strobe(strobe)
  );

  assign activeSrc = actSrc;
  assign pwrMode   = mode;
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rdData,
  input logic       wakeReq,
  input logic       wdtEn,
  input logic       timerKeepAlive,
  input logic       priReady,
  input logic       secReady,
  input logic       rcReady,
  input logic       priEn,
  input logic       secEn,
  input logic       rcEn,
  input logic [1:0] activeSrc,
  input logic [1:0] pwrMode,
  input logic       cpuClkEn,
  input logic       periClkEn
);
  p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 8'h74) == 8'h00);

  p_pri_switch_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeSrc) && activeSrc == 2'd1) |-> $past(priReady && rdData[3]));

  p_sec_switch_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeSrc) && activeSrc == 2'd2) |-> $past(secReady));

  p_rc_switch_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeSrc) && activeSrc == 2'd3) |-> $past(rcReady));

  p_idle_clocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode == 2'd1 |-> (!cpuClkEn && periClkEn));

  p_sleep_clocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode == 2'd2 |-> (!cpuClkEn && !periClkEn && !priEn));

  p_pri_idle_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode == 2'd1 && activeSrc == 2'd1) |-> priEn);

  p_wdt_rc_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdtEn |-> rcEn);

  p_keep_sec_r8: assert property (@(posedge clk) disable iff (!rstN)
    timerKeepAlive |-> secEn);

  p_wake_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode != 2'd0 && wakeReq) |=> pwrMode == 2'd0);
endmodule

bind clkmode_top clkmode_chk u_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .wakeReq(wakeReq),
  .wdtEn(wdtEn), .timerKeepAlive(timerKeepAlive),
  .priReady(priReady), .secReady(secReady), .rcReady(rcReady),
  .priEn(priEn), .secEn(secEn), .rcEn(rcEn),
  .activeSrc(activeSrc), .pwrMode(pwrMode),
  .cpuClkEn(cpuClkEn), .periClkEn(periClkEn)
);

// File: tb/clkmode_top_tb.sv
`timescale 1ns/1ps
module clkmode_top_tb;
  localparam int OST = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       cfgPriDefault = 1'b1;
  logic       cfgHsTwoSpeed = 1'b0;
  logic       sleepReq = 1'b0;
  logic       wakeReq = 1'b0;
  logic       wdtEn = 1'b0;
  logic       timerKeepAlive = 1'b0;
  logic       priReady = 1'b1;
  logic       secReady = 1'b1;
  logic       rcReady = 1'b1;
  logic       priEn, secEn, rcEn, cpuClkEn, periClkEn;
  logic [1:0] activeSrc, pwrMode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkmode_top #(.OST_CYCLES(OST)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cfgPriDefault(cfgPriDefault), .cfgHsTwoSpeed(cfgHsTwoSpeed),
    .sleepReq(sleepReq), .wakeReq(wakeReq), .wdtEn(wdtEn),
    .timerKeepAlive(timerKeepAlive), .priReady(priReady),
    .secReady(secReady), .rcReady(rcReady), .priEn(priEn), .secEn(secEn),
    .rcEn(rcEn), .activeSrc(activeSrc), .pwrMode(pwrMode),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic strap, input logic hs);
    rstN = 1'b0;
    cfgPriDefault = strap;
    cfgHsTwoSpeed = hs;
    wrEn = 1'b0; sleepReq = 1'b0; wakeReq = 1'b0;
    wdtEn = 1'b0; timerKeepAlive = 1'b0;
    priReady = 1'b1; secReady = 1'b1; rcReady = 1'b1;
    tick(2);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] d);
    wrEn = 1'b1;
    wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  function automatic int expSrc(input int sel, input int strap);
    if (sel == 3) return 3;
    if (sel == 2) return 1;
    if (sel == 1) return 2;
    return (strap != 0) ? 1 : 3;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset state, R1 R2 R4
    doReset(1'b1, 1'b0);
    check("R1 reset read", rdData, 8'h08);
    check("R2 reset active strap1", activeSrc, 1);
    check("R11 reset run mode", pwrMode, 0);

    // R2 sweep: every select code against both straps
    for (int strap = 0; strap < 2; strap++) begin
      for (int sel = 0; sel < 4; sel++) begin
        doReset(strap[0], 1'b0);
        busWrite(8'(sel));
        check("R1 read back select", rdData, 8'h08 | sel);
        tick(1);
        check("R2 decoded source", activeSrc, expSrc(sel, strap));
      end
    end

    // R1: unimplemented and status bits not writable
    doReset(1'b1, 1'b0);
    busWrite(8'hFF);
    check("R1 write all ones", rdData, 8'h8B);
    busWrite(8'h74);
    check("R1 unimplemented bits ignored", rdData, 8'h08);
    doReset(1'b0, 1'b1);
    check("R4 status reset with two-speed", rdData, 8'h00);
    busWrite(8'h08);
    check("R1 status bit read-only", rdData, 8'h00);

    // R4 start-up timing from reset with primary active
    doReset(1'b1, 1'b1);
    tick(OST - 1);
    check("R4 status before expiry", rdData[3], 0);
    tick(1);
    check("R4 status at expiry", rdData[3], 1);

    // R3 R11: switch waits for ready
    doReset(1'b0, 1'b0);
    secReady = 1'b0;
    busWrite(8'h01);
    tick(3);
    check("R3 source held until ready", activeSrc, 3);
    check("R11 target enabled while pending", secEn, 1);
    check("R11 old source kept on while pending", rcEn, 1);
    check("R11 unused primary off", priEn, 0);
    secReady = 1'b1;
    tick(1);
    check("R3 switch after ready", activeSrc, 2);
    check("R11 old source off after switch", rcEn, 0);

    // R3 R4: switch to primary waits for the start-up timer
    doReset(1'b0, 1'b1);
    busWrite(8'h02);
    check("R11 primary enabled as target", priEn, 1);
    tick(OST);
    check("R4 status after primary runs", rdData[3], 1);
    check("R3 primary not yet active", activeSrc, 3);
    tick(1);
    check("R3 primary active after timer", activeSrc, 1);

    // R5 R6 R7 R8 R9 sweep: each source with both idle settings
    for (int s = 1; s < 4; s++) begin
      for (int idl = 0; idl < 2; idl++) begin
        int sel;
        int src;
        sel = (s == 1) ? 2 : ((s == 2) ? 1 : 3);
        src = expSrc(sel, 1);
        doReset(1'b1, 1'b0);
        busWrite(8'((idl << 7) | sel));
        tick(1);
        sleepReq = 1'b1;
        tick(1);
        sleepReq = 1'b0;
        check(idl ? "R5 idle mode code" : "R6 sleep mode code", pwrMode, idl ? 1 : 2);
        check("R5 R6 cpu clock off", cpuClkEn, 0);
        check("R5 R6 peripheral clock", periClkEn, idl);
        check("R7 primary enable", priEn, (idl == 1 && src == 1) ? 1 : 0);
        check("R6 secondary enable", secEn, (idl == 1 && src == 2) ? 1 : 0);
        check("R6 rc enable", rcEn, (idl == 1 && src == 3) ? 1 : 0);
        wdtEn = 1'b1;
        timerKeepAlive = 1'b1;
        #1;
        check("R8 watchdog keeps rc", rcEn, 1);
        check("R8 keep-alive keeps secondary", secEn, 1);
        wdtEn = 1'b0;
        timerKeepAlive = 1'b0;
        wakeReq = 1'b1;
        tick(1);
        wakeReq = 1'b0;
        check("R9 wake returns to run", pwrMode, 0);
        check("R9 cpu clock back", cpuClkEn, 1);
      end
    end

    // R9: sleep ignored while wake is high
    doReset(1'b1, 1'b0);
    sleepReq = 1'b1;
    wakeReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    wakeReq = 1'b0;
    check("R9 sleep ignored during wake", pwrMode, 0);

    // R10: wake from sleep with primary restarts the timer
    doReset(1'b1, 1'b0);
    sleepReq = 1'b1;
    tick(1);
    sleepReq = 1'b0;
    tick(2);
    check("R10 status kept during sleep", rdData[3], 1);
    wakeReq = 1'b1;
    tick(1);
    wakeReq = 1'b0;
    check("R10 status cleared on wake", rdData[3], 0);
    tick(OST - 1);
    check("R10 status before expiry", rdData[3], 0);
    tick(1);
    check("R10 status after expiry", rdData[3], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule